// File: doc/BRIEF.md
# Modulation Depth Calibration Controller

This controller trims the depth of the frequency modulation applied to a clock synthesizer. It measures the actual frequency deviation in closed loop and adjusts an 8-bit trim code, which sets the reference level of the stage that turns frequency into modulation current. A configuration write carries an enable bit, a 2-bit depth code and a rate bit. A write with enable set and a non-zero depth starts a calibration. The block first opens a counting gate of a fixed number of reference cycles with modulation off. The edge count from that window is the centre count. The block then resolves the trim code one bit at a time, starting at the MSB. For each trial it counts over the same window with the oscillator held at its modulation peak.

The oscillator feeds the block with a count, for every reference cycle, of the modulated-clock edges seen in that cycle. The block accumulates these counts while the gate is open. It exposes four observation values: the last window count, the offset of that count from the centre count, the signed difference between that offset and the target, and the trim code. A status bit stays high while a run is enabled and has seen no fault. A completion flag goes high when the routine ends, and the final code then stays on the output.

Top module: `fm_depth_cal`

## Requirements
- R1: A write with cfgEnable=1 and a non-zero cfgDepth starts a run. On the next cycle calStatus=1, calDone=0, gateOn=1 and modPeak=0, and this centre window stays open for exactly WINDOW (1024) cycles.
- R2: modDepth and modRate show the depth and rate fields of the most recent configuration write. After reset both are 0.
- R3: The target offset is T=(floor(C/64)+floor(C/256)+floor(C/2048))·k, where C is the centre count and k is the depth code. Codes 1, 2 and 3 select k=1, 2 and 3, which give about 2, 4 and 6 percent.
- R4: After the centre window come DAC_W (8) trials, bit 7 first. Each trial sets its bit in dacCode and then opens a window with modPeak=1, which is only ever high while gateOn=1. The trial bit is kept when the measured offset is not above T. For a monotonic oscillator the final dacCode is therefore the largest code whose offset is at most T.
- R5: At the end of each peak window, measCount holds that window's count, offsetCount holds measCount−C (signed) and diffCount holds offsetCount−T (signed).
- R6: calStatus is 1 whenever a counting gate is open, and it stays 1 through the run and after a normal completion until the next write.
- R7: At the end of the last trial calDone rises. calDone and dacCode then hold until the next configuration write.
- R8: If a window's count exceeds 2^COUNT_W−1 (4095), the run stops at the end of that window. The block returns to idle with calStatus=0 and calDone=0.
- R9: A write with cfgEnable=0, in any state, returns the block to idle on the next cycle with calStatus=0, calDone=0 and gateOn=0. dacCode keeps its value.
- R10: A write with cfgEnable=1 and depth code 00 opens no window. On the next cycle calDone=1 and calStatus=0, and dacCode is unchanged.
- R11: After reset dacCode=0, calStatus=0, calDone=0, gateOn=0 and modPeak=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Enable bit of the write |
| cfgDepth | input | 2 | Depth code of the write (00 = off, 01/10/11 = 2/4/6 %) |
| cfgRate | input | 1 | Rate bit of the write (0 = 100 kHz, 1 = 200 kHz) |
| oscEdges | input | EDGE_W (3) | Modulated-clock edges seen in this reference cycle |
| gateOn | output | 1 | Counting gate open |
| modPeak | output | 1 | Request for the oscillator to sit at its modulation peak |
| modDepth | output | 2 | Registered depth code |
| modRate | output | 1 | Registered rate bit |
| dacCode | output | DAC_W (8) | Trim code |
| calStatus | output | 1 | Run enabled and free of fault |
| calDone | output | 1 | Routine complete |
| measCount | output | COUNT_W (12) | Last window count |
| offsetCount | output | COUNT_W+1 | Signed offset of the last peak count from the centre count |
| diffCount | output | COUNT_W+2 | Signed offset minus target |

## Verification
The assertions check on every cycle how the block responds to each kind of configuration write (start, disable, depth-zero skip). They also check that the peak request never appears outside an open gate, that an open gate implies good status, and that a completed result holds. The final trim code, the target arithmetic, the observation values and the overflow abort depend on whole counting windows and on the oscillator's response. Only the bench's scenarios can show these: it models the oscillator with injected process errors and finds the expected code by exhaustive search.

// File: rtl/fm_depth_cal_pkg.sv
package fm_depth_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CENTRE,
    ST_TRIAL,
    ST_PEAK,
    ST_JUDGE,
    ST_DONE
  } calState_t;

  typedef struct packed {
    logic clear;       // restart window counters
    logic count;       // accumulate edges this cycle
    logic takeCentre;  // latch centre count
    logic takePeak;    // latch peak count, offset and difference
    logic applyTrial;  // set trial bit in the code
    logic judge;       // keep or drop trial bit, move to next bit
    logic resetDac;    // clear code and point at MSB
  } calStrobe_t;

endpackage

// File: rtl/fm_depth_cal_dp.sv
module fm_depth_cal_dp
  import fm_depth_cal_pkg::*;
#(
  parameter int WINDOW  = 1024,
  parameter int COUNT_W = 12,
  parameter int EDGE_W  = 3,
  parameter int DAC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  calStrobe_t                stb,
  input  logic [1:0]                depthSel,
  input  logic [EDGE_W-1:0]         oscEdges,
  output logic                      winLast,
  output logic                      winOvf,
  output logic                      lastBit,
  output logic [DAC_W-1:0]          dacCode,
  output logic [COUNT_W-1:0]        measCount,
  output logic signed [COUNT_W:0]   offsetCount,
  output logic signed [COUNT_W+1:0] diffCount
);

  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [WIN_W-1:0]          winCnt;
  logic [COUNT_W:0]          acc;
  logic [COUNT_W:0]          accNext;
  logic                      ovfSeen;
  logic [COUNT_W-1:0]        centre;
  logic [DAC_W-1:0]          trialMask;
  logic [COUNT_W-1:0]        tBase;
  logic [COUNT_W+1:0]        target;
  logic signed [COUNT_W:0]   offsetNext;
  logic signed [COUNT_W+1:0] diffNext;

  assign accNext = acc + {{(COUNT_W+1-EDGE_W){1'b0}}, oscEdges};
  assign winLast = (winCnt == WIN_W'(WINDOW - 1));
  assign winOvf  = ovfSeen | accNext[COUNT_W];
  assign lastBit = trialMask[0];

  // target: roughly 2 % of the centre count, scaled by depth code
  assign tBase = (centre >> 6) + (centre >> 8) + (centre >> 11);
  always_comb begin
    case (depthSel)
      2'd1:    target = {2'b00, tBase};
      2'd2:    target = {1'b0, tBase, 1'b0};
      2'd3:    target = {2'b00, tBase} + {1'b0, tBase, 1'b0};
      default: target = '0;
    endcase
  end

  assign offsetNext = $signed({1'b0, accNext[COUNT_W-1:0]}) - $signed({1'b0, centre});
  assign diffNext   = {offsetNext[COUNT_W], offsetNext} - $signed(target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      acc     <= '0;
      ovfSeen <= 1'b0;
    end else if (stb.clear) begin
      winCnt  <= '0;
      acc     <= '0;
      ovfSeen <= 1'b0;
    end else if (stb.count) begin
      winCnt <= winCnt + 1'b1;
      if (accNext[COUNT_W]) ovfSeen <= 1'b1;
      else                  acc     <= accNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      centre      <= '0;
      measCount   <= '0;
      offsetCount <= '0;
      diffCount   <= '0;
    end else if (stb.takeCentre) begin
      centre    <= accNext[COUNT_W-1:0];
      measCount <= accNext[COUNT_W-1:0];
    end else if (stb.takePeak) begin
      measCount   <= accNext[COUNT_W-1:0];
      offsetCount <= offsetNext;
      diffCount   <= diffNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      trialMask <= '0;
    end else if (stb.resetDac) begin
      dacCode   <= '0;
      trialMask <= {1'b1, {(DAC_W-1){1'b0}}};
    end else if (stb.applyTrial) begin
      dacCode <= dacCode | trialMask;
    end else if (stb.judge) begin
      if (diffCount > 0) dacCode <= dacCode & ~trialMask;
      trialMask <= trialMask >> 1;
    end
  end

endmodule

// File: rtl/fm_depth_cal_ctl.sv
module fm_depth_cal_ctl
  import fm_depth_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       cfgEnable,
  input  logic [1:0] cfgDepth,
  input  logic       cfgRate,
  input  logic       winLast,
  input  logic       winOvf,
  input  logic       lastBit,
  output calStrobe_t stb,
  output logic       gateOn,
  output logic       modPeak,
  output logic [1:0] modDepth,
  output logic       modRate,
  output logic       calStatus,
  output logic       calDone
);

  calState_t state;
  logic      startRun;
  logic      idleCycle;

  assign startRun  = cfgWrite && cfgEnable && (cfgDepth != 2'd0);
  assign idleCycle = !cfgWrite;

  always_comb begin
    stb            = '0;
    stb.clear      = startRun || (idleCycle && state == ST_TRIAL);
    stb.resetDac   = startRun;
    stb.count      = idleCycle && (state == ST_CENTRE || state == ST_PEAK);
    stb.takeCentre = idleCycle && state == ST_CENTRE && winLast && !winOvf;
    stb.takePeak   = idleCycle && state == ST_PEAK && winLast && !winOvf;
    stb.applyTrial = idleCycle && state == ST_TRIAL;
    stb.judge      = idleCycle && state == ST_JUDGE;
  end

  assign gateOn  = (state == ST_CENTRE) || (state == ST_PEAK);
  assign modPeak = (state == ST_PEAK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      calStatus <= 1'b0;
      calDone   <= 1'b0;
      modDepth  <= 2'd0;
      modRate   <= 1'b0;
    end else if (cfgWrite) begin
      modDepth <= cfgDepth;
      modRate  <= cfgRate;
      calDone  <= cfgEnable && (cfgDepth == 2'd0);
      if (!cfgEnable) begin
        state     <= ST_IDLE;
        calStatus <= 1'b0;
      end else if (cfgDepth == 2'd0) begin
        state     <= ST_DONE;
        calStatus <= 1'b0;
      end else begin
        state     <= ST_CENTRE;
        calStatus <= 1'b1;
      end
    end else begin
      case (state)
        ST_CENTRE, ST_PEAK: begin
          if (winLast) begin
            if (winOvf) begin
              state     <= ST_IDLE;
              calStatus <= 1'b0;
            end else begin
              state <= (state == ST_CENTRE) ? ST_TRIAL : ST_JUDGE;
            end
          end
        end
        ST_TRIAL: state <= ST_PEAK;
        ST_JUDGE: begin
          if (lastBit) begin
            state   <= ST_DONE;
            calDone <= 1'b1;
          end else begin
            state <= ST_TRIAL;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/fm_depth_cal.sv
module fm_depth_cal
  import fm_depth_cal_pkg::*;
#(
  parameter int WINDOW  = 1024,
  parameter int COUNT_W = 12,
  parameter int EDGE_W  = 3,
  parameter int DAC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrite,
  input  logic                      cfgEnable,
  input  logic [1:0]                cfgDepth,
  input  logic                      cfgRate,
  input  logic [EDGE_W-1:0]         oscEdges,
  output logic                      gateOn,
  output logic                      modPeak,
  output logic [1:0]                modDepth,
  output logic                      modRate,
  output logic [DAC_W-1:0]          dacCode,
  output logic                      calStatus,
  output logic                      calDone,
  output logic [COUNT_W-1:0]        measCount,
  output logic signed [COUNT_W:0]   offsetCount,
  output logic signed [COUNT_W+1:0] diffCount
);

  calStrobe_t stb;
  logic       winLast;
  logic       winOvf;
  logic       lastBit;

  fm_depth_cal_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrite  (cfgWrite),
    .cfgEnable (cfgEnable),
    .cfgDepth  (cfgDepth),
    .cfgRate   (cfgRate),
    .winLast   (winLast),
    .winOvf    (winOvf),
    .lastBit   (lastBit),
    .stb       (stb),
    .gateOn    (gateOn),
    .modPeak   (modPeak),
    .modDepth  (modDepth),
    .modRate   (modRate),
    .calStatus (calStatus),
    .calDone   (calDone)
  );

  fm_depth_cal_dp #(
    .WINDOW  (WINDOW),
    .COUNT_W (COUNT_W),
    .EDGE_W  (EDGE_W),
    .DAC_W   (DAC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .depthSel    (modDepth),
    .oscEdges    (oscEdges),
    .winLast     (winLast),
    .winOvf      (winOvf),
    .lastBit     (lastBit),
    .dacCode     (dacCode),
    .measCount   (measCount),
    .offsetCount (offsetCount),
    .diffCount   (diffCount)
  );

endmodule

// File: rtl/fm_depth_cal_chk.sv
module fm_depth_cal_chk #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrite,
  input logic             cfgEnable,
  input logic [1:0]       cfgDepth,
  input logic             gateOn,
  input logic             modPeak,
  input logic [DAC_W-1:0] dacCode,
  input logic             calStatus,
  input logic             calDone
);

  // R1
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgEnable && cfgDepth != 2'd0) |=> (calStatus && !calDone && gateOn && !modPeak));

  // R4
  peak_in_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    modPeak |-> gateOn);

  // R6
  gate_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> calStatus);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !cfgWrite) |=> (calDone && $stable(dacCode)));

  // R9
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !cfgEnable) |=> (!calStatus && !calDone && !gateOn && $stable(dacCode)));

  // R10
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgEnable && cfgDepth == 2'd0) |=> (calDone && !calStatus && !gateOn && $stable(dacCode)));

endmodule

bind fm_depth_cal fm_depth_cal_chk #(.DAC_W(DAC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrite  (cfgWrite),
  .cfgEnable (cfgEnable),
  .cfgDepth  (cfgDepth),
  .gateOn    (gateOn),
  .modPeak   (modPeak),
  .dacCode   (dacCode),
  .calStatus (calStatus),
  .calDone   (calDone)
);

// File: tb/fm_depth_cal_test.sv
`timescale 1ns/1ps
module fm_depth_cal_test;

  localparam int WINDOW  = 1024;
  localparam int COUNT_W = 12;
  localparam int EDGE_W  = 3;
  localparam int DAC_W   = 8;
  localparam int GAIN    = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic cfgEnable = 1'b0;
  logic [1:0] cfgDepth = 2'd0;
  logic cfgRate = 1'b0;
  logic [EDGE_W-1:0] oscEdges = '0;
  logic gateOn, modPeak, modRate, calStatus, calDone;
  logic [1:0] modDepth;
  logic [DAC_W-1:0] dacCode;
  logic [COUNT_W-1:0] measCount;
  logic signed [COUNT_W:0] offsetCount;
  logic signed [COUNT_W+1:0] diffCount;

  int total = 0;
  int bad = 0;
  int oscCentre = 2048;
  int oscErr = 0;
  int gIdx = 0;
  int curN = 0;

  // behavioural model of the expected control sequence
  int mState = 0;  // 0 idle, 1 centre, 2 trial, 3 peak, 4 judge, 5 done
  int mCnt = 0;
  int mAcc = 0;
  int mBit = 0;
  bit mStatus = 0;
  bit mDone = 0;

  always #4 clk = ~clk;

  fm_depth_cal #(
    .WINDOW(WINDOW), .COUNT_W(COUNT_W), .EDGE_W(EDGE_W), .DAC_W(DAC_W)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .cfgDepth(cfgDepth), .cfgRate(cfgRate), .oscEdges(oscEdges),
    .gateOn(gateOn), .modPeak(modPeak), .modDepth(modDepth), .modRate(modRate),
    .dacCode(dacCode), .calStatus(calStatus), .calDone(calDone),
    .measCount(measCount), .offsetCount(offsetCount), .diffCount(diffCount)
  );

  function automatic int offFn(int code, int depth);
    return (code * depth * GAIN) / 256 + oscErr;
  endfunction

  function automatic int tgtFn(int c, int depth);
    return (c / 64 + c / 256 + c / 2048) * depth;
  endfunction

  function automatic int bestFn(int c, int depth);
    int best = 0;
    for (int d = 0; d < 256; d++)
      if (offFn(d, depth) <= tgtFn(c, depth)) best = d;
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // oscillator model: spreads N edges evenly over a window
  always @(negedge clk) begin
    if (gateOn) begin
      if (gIdx == 0) curN = modPeak ? oscCentre + offFn(int'(dacCode), int'(modDepth)) : oscCentre;
      oscEdges <= EDGE_W'(((gIdx + 1) * curN) / WINDOW - (gIdx * curN) / WINDOW);
      gIdx = gIdx + 1;
      if (gIdx == WINDOW) gIdx = 0;
    end else begin
      oscEdges <= '0;
      gIdx = 0;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mStatus = 0; mDone = 0; mCnt = 0; mAcc = 0;
    end else if (cfgWrite) begin
      if (!cfgEnable) begin
        mState = 0; mStatus = 0; mDone = 0;
      end else if (cfgDepth == 2'd0) begin
        mState = 5; mStatus = 0; mDone = 1;
      end else begin
        mState = 1; mStatus = 1; mDone = 0; mCnt = 0; mAcc = 0; mBit = DAC_W - 1;
      end
    end else begin
      case (mState)
        1, 3: begin
          mAcc += int'(oscEdges);
          mCnt++;
          if (mCnt == WINDOW) begin
            if (mAcc > (1 << COUNT_W) - 1) begin
              mState = 0; mStatus = 0;
            end else begin
              mState = (mState == 1) ? 2 : 4;
            end
          end
        end
        2: begin mState = 3; mCnt = 0; mAcc = 0; end
        4: begin
          if (mBit == 0) begin mState = 5; mDone = 1; end
          else begin mBit--; mState = 2; end
        end
        default: ;
      endcase
    end
  end

  // per-cycle comparison against the model (R1, R4, R6, R7)
  always @(negedge clk) begin
    if (rstN) begin
      check(calStatus == mStatus, "R6 cycle status", calStatus, mStatus);
      check(calDone == mDone, "R7 cycle done", calDone, mDone);
      check(gateOn == (mState == 1 || mState == 3), "R1 cycle gate", gateOn, (mState == 1 || mState == 3));
      check(modPeak == (mState == 3), "R4 cycle peak", modPeak, (mState == 3));
    end
  end

  task automatic writeCfg(input bit en, input int depth, input bit rate);
    @(negedge clk);
    cfgWrite = 1'b1; cfgEnable = en; cfgDepth = 2'(depth); cfgRate = rate;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic runCal(input int c, input int err, input int depth, input bit rate);
    int best, lastTrial, guard;
    oscCentre = c; oscErr = err;
    writeCfg(1'b1, depth, rate);
    check(calStatus && gateOn && !modPeak && !calDone, "R1 start", {calStatus, gateOn, modPeak, calDone}, 4'b1100);
    check(modDepth == 2'(depth), "R2 depth reg", modDepth, depth);
    check(modRate == rate, "R2 rate reg", modRate, rate);
    guard = 0;
    while (!calDone && guard < 12000) begin
      @(negedge clk);
      guard++;
    end
    best = bestFn(c, depth);
    lastTrial = best | 1;
    check(calDone == 1'b1, "R7 done raised", calDone, 1);
    check(calStatus == 1'b1, "R6 status after done", calStatus, 1);
    check(int'(dacCode) == best, "R4 final code", dacCode, best);
    check(int'(measCount) == c + offFn(lastTrial, depth), "R5 meas count", measCount, c + offFn(lastTrial, depth));
    check(int'(offsetCount) == offFn(lastTrial, depth), "R5 offset count", offsetCount, offFn(lastTrial, depth));
    check(int'(diffCount) == offFn(lastTrial, depth) - tgtFn(c, depth), "R3 diff vs target",
          diffCount, offFn(lastTrial, depth) - tgtFn(c, depth));
    repeat (50) @(negedge clk);
    check(calDone == 1'b1 && int'(dacCode) == best, "R7 hold", dacCode, best);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DAC_W-1:0] held;
    repeat (5) @(negedge clk);
    check(dacCode == 0 && !calStatus && !calDone && !gateOn && !modPeak, "R11 reset",
          {dacCode, calStatus, calDone, gateOn, modPeak}, 0);
    check(modDepth == 0 && modRate == 0, "R2 reset regs", {modDepth, modRate}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runCal(2048, 0, 1, 1'b0);
    runCal(2048, 10, 2, 1'b1);
    runCal(1800, -15, 3, 1'b0);

    // R10: depth 00 skips calibration
    held = dacCode;
    writeCfg(1'b1, 0, 1'b1);
    check(calDone && !calStatus && !gateOn, "R10 skip flags", {calDone, calStatus, gateOn}, 3'b100);
    check(dacCode == held, "R10 code kept", dacCode, held);
    check(modDepth == 0 && modRate == 1'b1, "R2 skip regs", {modDepth, modRate}, 1);
    repeat (10) @(negedge clk);
    check(!gateOn && dacCode == held, "R10 no window", gateOn, 0);

    // R9: disable in the middle of a run
    oscCentre = 2048; oscErr = 0;
    writeCfg(1'b1, 2, 1'b0);
    repeat (3000) @(negedge clk);
    check(calStatus && modPeak, "R6 mid-run status", {calStatus, modPeak}, 3);
    @(negedge clk);
    held = dacCode;
    cfgWrite = 1'b1; cfgEnable = 1'b0; cfgDepth = 2'd2; cfgRate = 1'b0;
    @(negedge clk);
    cfgWrite = 1'b0;
    check(!calStatus && !calDone && !gateOn, "R9 disable flags", {calStatus, calDone, gateOn}, 0);
    check(dacCode == held, "R9 code kept", dacCode, held);
    repeat (20) @(negedge clk);
    check(!gateOn && dacCode == held && !calDone, "R9 stays idle", dacCode, held);

    // R8: overflow of the centre window
    oscCentre = 4500; oscErr = 0;
    writeCfg(1'b1, 1, 1'b0);
    repeat (1030) @(negedge clk);
    check(!calStatus && !calDone && !gateOn, "R8 overflow abort", {calStatus, calDone, gateOn}, 0);

    // recovery after a failure
    runCal(2048, 5, 1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule